// File: doc/BRIEF.md
# LIN Master Frame Controller

This block runs the frame level of a LIN master on top of an external byte transmitter and receiver. On a start strobe it drives a long dominant break onto the bus, lets the line recover for one bit-time, and then sends the synchronisation pattern and the identifier. On a transmit frame it goes on to send the response bytes and a checksum. On a receive frame it collects the slave's bytes and checks the checksum that follows them. Each byte it sends is compared with the copy the receiver reads back from the bus, and a mismatch ends the frame at once.

Receive frames are bounded by a clock-cycle budget that is counted from the start strobe. Separately, a wake-up command sends a bare break and holds the controller busy for a programmable number of cycles after it. A bus monitor flags a long dominant period caused by another node as a wake event, and it reports bus sleep after a long run of bit-times with no edge. Bit timing comes from an external one-cycle strobe that pulses once per bit-time.

Top module: `lin_frame_engine`

## Requirements
- R1: After reset `tx_ready` is 1, `brk_drive` and `byte_tx_req` are 0, and every error flag and `wake_flag` is 0.
- R2: A frame start or a wake command holds `brk_drive` high for exactly BRK_BITS (13) bit strobes. The line is then released for one strobe, and no byte is requested while the break is driven.
- R3: A transmit frame (`frame_dir_tx`=1) requests the bytes 0x55, the identifier, the data bytes from index 0 to `frame_len`-1 (`frame_len` from 1 to MAX_DATA), and the checksum, in that order. `frame_done` then pulses for one cycle.
- R4: The checksum is the bitwise inverse of the 8-bit sum of the data bytes only, where each carry out of bit 7 is added back into bit 0.
- R5: The next byte is requested only after the readback of the previous one. A readback that differs from the sent byte sets `err_bit`, stops all further requests, and makes `tx_ready` 1 in the cycle after the readback strobe.
- R6: On a receive frame (`frame_dir_tx`=0), after the identifier readback the next `frame_len` bytes appear on `rx_dat` with `rx_dat_valid`. The byte after them is compared with the expected checksum: a match pulses `frame_done`, and a mismatch sets `err_csum` with no `frame_done`.
- R7: A receive frame that has not finished when `tmo_limit` cycles have passed since the start edge returns to idle and sets `err_timeout`, so `tx_ready` is 0 for exactly `tmo_limit` cycles. A receive frame that finishes earlier sets no flag.
- R8: `frame_go` and `wake_go` are ignored while `tx_ready` is 0, and an ignored strobe adds or changes no byte request.
- R9: After a wake break and its one-strobe release, `tx_ready` stays 0 for a further `wake_delay` cycles.
- R10: `wake_flag` is set when the bus stays low for at least DET_BITS (11) bit strobes while the controller is idle. A shorter low period does not set it, and neither does the controller's own break.
- R11: The flags are sticky until a one is written to their bit of `flag_clr`: bit 0 clears `err_bit`, bit 1 clears `err_timeout`, bit 2 clears `err_csum` and bit 3 clears `wake_flag`. Other flags are unaffected.
- R12: `sleep_flag` becomes 1 after SLEEP_BITS (25000 by default) bit strobes with no bus edge. An edge drops it in the next cycle and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit-time |
| bus_rx | input | 1 | Synchronised bus level (1 = recessive) |
| frame_go | input | 1 | Start-frame strobe |
| frame_dir_tx | input | 1 | 1: controller sends the response; 0: slave sends it |
| frame_id | input | 8 | Identifier byte to send |
| frame_len | input | LEN_W | Number of data bytes |
| resp_byte | input | 8 | Response byte selected by `resp_idx` |
| resp_idx | output | IDX_W | Index of the data byte being sent or received |
| tmo_limit | input | TMO_W | Receive-frame budget in cycles |
| wake_go | input | 1 | Wake-break command strobe |
| wake_delay | input | WD_W | Hold-off after a wake break, in cycles |
| flag_clr | input | 4 | Write-one-to-clear strobes for the flags |
| byte_tx_req | output | 1 | Request to the byte transmitter |
| byte_tx_data | output | 8 | Byte to transmit |
| byte_rx_valid | input | 1 | Byte received from the bus |
| byte_rx_data | input | 8 | Received byte |
| brk_drive | output | 1 | Force the bus dominant |
| tx_ready | output | 1 | Controller idle and able to start |
| frame_done | output | 1 | Frame finished without error |
| rx_dat_valid | output | 1 | Received data byte strobe |
| rx_dat | output | 8 | Received data byte |
| err_bit | output | 1 | Readback mismatch flag |
| err_timeout | output | 1 | Slave timeout flag |
| err_csum | output | 1 | Checksum mismatch flag |
| wake_flag | output | 1 | Wake break seen from another node |
| sleep_flag | output | 1 | Bus inactive for SLEEP_BITS bit-times |

## Verification
Each result has its own due time. A readback mismatch shows on `err_bit` and `tx_ready` in the cycle after the readback strobe, so the bench samples on the first falling edge after that strobe. The timeout and wake hold-off are measured by counting falling edges with `tx_ready` low: the expected count is `tmo_limit` from the start edge, and `wake_delay`+4 from the end of the break, because the bench's bit strobe has a 4-cycle period. Break length and sleep onset are counted in strobes rather than cycles, and flag clears are checked one edge after the strobe.

// File: rtl/lin_pkg.sv
package lin_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BRK,
        S_DLM,
        S_SEND,
        S_ECHO,
        S_RECV,
        S_WBRK,
        S_WDLM,
        S_WWAIT
    } lin_state_e;

    typedef enum logic [1:0] {
        P_SYNC,
        P_ID,
        P_DATA,
        P_CSUM
    } lin_phase_e;

    localparam logic [7:0] SYNC_PATTERN = 8'h55;

    localparam int CLR_BIT  = 0;
    localparam int CLR_TMO  = 1;
    localparam int CLR_CSUM = 2;
    localparam int CLR_WAKE = 3;

endpackage

// File: rtl/lin_csum_acc.sv
module lin_csum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] sum
);
    logic [7:0] sum_d, sum_q;
    logic [8:0] wide;

    always_comb begin
        wide  = {1'b0, sum_q} + {1'b0, din};
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add) begin
            // carry out of bit 7 wraps back into bit 0
            sum_d = wide[7:0] + {7'd0, wide[8]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;
endmodule

// File: rtl/lin_bus_mon.sv
module lin_bus_mon #(
    parameter int DET_BITS   = 11,
    parameter int SLEEP_BITS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bus_rx,
    input  logic det_en,
    output logic wake_det,
    output logic sleep_flag
);
    localparam int DW = $clog2(DET_BITS + 1);
    localparam int SW = $clog2(SLEEP_BITS + 1);

    typedef struct packed {
        logic [DW-1:0] low_cnt;
        logic [SW-1:0] idle_cnt;
        logic          prev;
    } mon_t;

    mon_t q, d;
    logic edge_seen;

    always_comb begin
        d         = q;
        wake_det  = 1'b0;
        edge_seen = (bus_rx != q.prev);
        d.prev    = bus_rx;

        if (!bus_rx) begin
            if (bit_tick && q.low_cnt != DW'(DET_BITS)) begin
                d.low_cnt = q.low_cnt + DW'(1);
                if (q.low_cnt == DW'(DET_BITS - 1) && det_en) wake_det = 1'b1;
            end
        end else begin
            d.low_cnt = '0;
        end

        if (edge_seen) begin
            d.idle_cnt = '0;
        end else if (bit_tick && q.idle_cnt != SW'(SLEEP_BITS)) begin
            d.idle_cnt = q.idle_cnt + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.low_cnt  <= '0;
            q.idle_cnt <= '0;
            q.prev     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sleep_flag = (q.idle_cnt == SW'(SLEEP_BITS));
endmodule

// File: rtl/lin_frame_engine.sv
module lin_frame_engine
    import lin_pkg::*;
#(
    parameter int MAX_DATA   = 8,
    parameter int TMO_W      = 16,
    parameter int WD_W       = 16,
    parameter int BRK_BITS   = 13,
    parameter int DET_BITS   = 11,
    parameter int SLEEP_BITS = 25000,
    localparam int LEN_W     = $clog2(MAX_DATA + 1),
    localparam int IDX_W     = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             bus_rx,
    input  logic             frame_go,
    input  logic             frame_dir_tx,
    input  logic [7:0]       frame_id,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [7:0]       resp_byte,
    output logic [IDX_W-1:0] resp_idx,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             wake_go,
    input  logic [WD_W-1:0]  wake_delay,
    input  logic [3:0]       flag_clr,
    output logic             byte_tx_req,
    output logic [7:0]       byte_tx_data,
    input  logic             byte_rx_valid,
    input  logic [7:0]       byte_rx_data,
    output logic             brk_drive,
    output logic             tx_ready,
    output logic             frame_done,
    output logic             rx_dat_valid,
    output logic [7:0]       rx_dat,
    output logic             err_bit,
    output logic             err_timeout,
    output logic             err_csum,
    output logic             wake_flag,
    output logic             sleep_flag
);
    localparam int BRK_CW = $clog2(BRK_BITS + 1);
    localparam int CNT_W  = (WD_W > BRK_CW) ? WD_W : BRK_CW;

    typedef struct packed {
        lin_state_e       st;
        lin_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] dcnt;
        logic [IDX_W-1:0] last;
        logic [TMO_W-1:0] tmo;
        logic [7:0]       txb;
        logic [7:0]       id;
        logic             dir_tx;
        logic             e_bit;
        logic             e_tmo;
        logic             e_cs;
        logic             wk;
        logic             done;
        logic             rxv;
        logic [7:0]       rxd;
    } eng_t;

    eng_t q, d;

    logic       cs_clr, cs_add;
    logic [7:0] cs_din, cs_sum, cs_expect;
    logic       wake_det, in_frame;
    logic [7:0] send_byte;
    logic [IDX_W-1:0] last_idx;

    lin_csum_acc u_csum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cs_clr),
        .add   (cs_add),
        .din   (cs_din),
        .sum   (cs_sum)
    );

    lin_bus_mon #(
        .DET_BITS   (DET_BITS),
        .SLEEP_BITS (SLEEP_BITS)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .bus_rx     (bus_rx),
        .det_en     (q.st == S_IDLE),
        .wake_det   (wake_det),
        .sleep_flag (sleep_flag)
    );

    assign cs_expect = ~cs_sum;

    // clamp the requested length to 1..MAX_DATA, stored as last index
    always_comb begin
        if (frame_len == '0)
            last_idx = '0;
        else if (frame_len > LEN_W'(MAX_DATA))
            last_idx = IDX_W'(MAX_DATA - 1);
        else
            last_idx = IDX_W'(frame_len - LEN_W'(1));
    end

    always_comb begin
        unique case (q.ph)
            P_SYNC:  send_byte = SYNC_PATTERN;
            P_ID:    send_byte = q.id;
            P_DATA:  send_byte = resp_byte;
            default: send_byte = cs_expect;
        endcase
    end

    assign in_frame = (q.st == S_BRK) || (q.st == S_DLM) || (q.st == S_SEND) ||
                      (q.st == S_ECHO) || (q.st == S_RECV);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.rxv   = 1'b0;
        cs_clr  = 1'b0;
        cs_add  = 1'b0;
        cs_din  = byte_rx_data;

        d.e_bit = q.e_bit & ~flag_clr[CLR_BIT];
        d.e_tmo = q.e_tmo & ~flag_clr[CLR_TMO];
        d.e_cs  = q.e_cs  & ~flag_clr[CLR_CSUM];
        d.wk    = (q.wk & ~flag_clr[CLR_WAKE]) | wake_det;

        unique case (q.st)
            S_IDLE: begin
                if (frame_go) begin
                    d.st     = S_BRK;
                    d.cnt    = '0;
                    d.tmo    = '0;
                    d.ph     = P_SYNC;
                    d.dcnt   = '0;
                    d.id     = frame_id;
                    d.dir_tx = frame_dir_tx;
                    d.last   = last_idx;
                    cs_clr   = 1'b1;
                end else if (wake_go) begin
                    d.st  = S_WBRK;
                    d.cnt = '0;
                end
            end
            S_BRK, S_WBRK: begin
                if (bit_tick) begin
                    if (q.cnt == CNT_W'(BRK_BITS - 1)) begin
                        d.st  = (q.st == S_BRK) ? S_DLM : S_WDLM;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
            S_DLM: begin
                if (bit_tick) d.st = S_SEND;
            end
            S_SEND: begin
                d.txb  = send_byte;
                d.st   = S_ECHO;
                cs_din = send_byte;
                cs_add = (q.ph == P_DATA);
            end
            S_ECHO: begin
                if (byte_rx_valid) begin
                    if (byte_rx_data != q.txb) begin
                        d.e_bit = 1'b1;
                        d.st    = S_IDLE;
                    end else begin
                        unique case (q.ph)
                            P_SYNC: begin
                                d.ph = P_ID;
                                d.st = S_SEND;
                            end
                            P_ID: begin
                                d.ph   = P_DATA;
                                d.dcnt = '0;
                                d.st   = q.dir_tx ? S_SEND : S_RECV;
                            end
                            P_DATA: begin
                                if (q.dcnt == q.last) d.ph = P_CSUM;
                                else                  d.dcnt = q.dcnt + IDX_W'(1);
                                d.st = S_SEND;
                            end
                            default: begin
                                d.done = 1'b1;
                                d.st   = S_IDLE;
                            end
                        endcase
                    end
                end
            end
            S_RECV: begin
                if (byte_rx_valid) begin
                    if (q.ph == P_DATA) begin
                        d.rxv  = 1'b1;
                        d.rxd  = byte_rx_data;
                        cs_add = 1'b1;
                        if (q.dcnt == q.last) d.ph = P_CSUM;
                        else                  d.dcnt = q.dcnt + IDX_W'(1);
                    end else begin
                        if (byte_rx_data == cs_expect) d.done = 1'b1;
                        else                           d.e_cs = 1'b1;
                        d.st = S_IDLE;
                    end
                end
            end
            S_WDLM: begin
                if (bit_tick) begin
                    d.st  = S_WWAIT;
                    d.cnt = '0;
                end
            end
            S_WWAIT: begin
                if (wake_delay == '0 || q.cnt >= CNT_W'(wake_delay) - CNT_W'(1))
                    d.st = S_IDLE;
                else
                    d.cnt = q.cnt + CNT_W'(1);
            end
            default: d.st = S_IDLE;
        endcase

        // slave response budget, only for frames the slave answers
        if (in_frame && !q.dir_tx) begin
            if (d.st != S_IDLE && q.tmo == tmo_limit - TMO_W'(1)) begin
                d.st    = S_IDLE;
                d.e_tmo = 1'b1;
            end else begin
                d.tmo = q.tmo + TMO_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign resp_idx     = q.dcnt;
    assign byte_tx_req  = (q.st == S_SEND);
    assign byte_tx_data = send_byte;
    assign brk_drive    = (q.st == S_BRK) || (q.st == S_WBRK);
    assign tx_ready     = (q.st == S_IDLE);
    assign frame_done   = q.done;
    assign rx_dat_valid = q.rxv;
    assign rx_dat       = q.rxd;
    assign err_bit      = q.e_bit;
    assign err_timeout  = q.e_tmo;
    assign err_csum     = q.e_cs;
    assign wake_flag    = q.wk;
endmodule

// File: rtl/lin_frame_engine_chk.sv
module lin_frame_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       brk_drive,
    input logic       byte_tx_req,
    input logic       tx_ready,
    input logic       frame_done,
    input logic       err_bit,
    input logic       err_timeout,
    input logic       err_csum,
    input logic       wake_flag,
    input logic [3:0] flag_clr
);
    AST_BRK_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_drive |-> !byte_tx_req); // R2

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_tx_req |-> !tx_ready); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R3

    AST_BITERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_bit) |-> tx_ready); // R5

    AST_CSUM_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_csum) |-> !frame_done); // R6

    AST_TMO_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> tx_ready); // R7

    AST_READY_NO_BRK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !brk_drive); // R9

    AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_bit && !flag_clr[0]) |=> err_bit); // R11

    AST_STICKY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !flag_clr[3]) |=> wake_flag); // R11
endmodule

bind lin_frame_engine lin_frame_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_drive   (brk_drive),
    .byte_tx_req (byte_tx_req),
    .tx_ready    (tx_ready),
    .frame_done  (frame_done),
    .err_bit     (err_bit),
    .err_timeout (err_timeout),
    .err_csum    (err_csum),
    .wake_flag   (wake_flag),
    .flag_clr    (flag_clr)
);

// File: tb/sim_lin_frame_engine.sv
`timescale 1ns/1ps
module sim_lin_frame_engine;
    localparam int SLP = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] tick_div = '0;
    logic bit_tick;
    logic ext_low = 1'b0;
    logic bus_rx;
    logic frame_go = 1'b0, frame_dir_tx = 1'b1;
    logic [7:0] frame_id = '0;
    logic [3:0] frame_len = 4'd1;
    logic [7:0] resp_byte;
    logic [2:0] resp_idx;
    logic [15:0] tmo_limit = 16'd2000;
    logic wake_go = 1'b0;
    logic [15:0] wake_delay = 16'd40;
    logic [3:0] flag_clr = '0;
    logic byte_tx_req;
    logic [7:0] byte_tx_data;
    logic byte_rx_valid = 1'b0;
    logic [7:0] byte_rx_data = '0;
    logic brk_drive, tx_ready, frame_done, rx_dat_valid;
    logic [7:0] rx_dat;
    logic err_bit, err_timeout, err_csum, wake_flag, sleep_flag;

    logic [63:0] cur_data = '0;
    int checks = 0, errors = 0;
    bit finished = 0;

    // bench-side byte UART and slave model
    logic clr_log = 1'b0;
    logic [7:0] tx_log [16];
    logic [7:0] rx_log [16];
    int log_n = 0, rx_n = 0, done_n = 0, brk_ticks = 0;
    int corrupt_at = 99;
    int echo_cnt = 0;
    logic [7:0] echo_dat = '0;
    logic slave_en = 1'b0;
    logic [7:0] sl_bytes [8];
    int sl_n = 0, sl_ptr = 0, sl_wait = 0;
    logic sl_act = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) tick_div <= tick_div + 2'd1;
    assign bit_tick = (tick_div == 2'd3);
    assign bus_rx = ~(brk_drive | ext_low);
    assign resp_byte = cur_data[{resp_idx, 3'b000} +: 8];

    lin_frame_engine #(.SLEEP_BITS(SLP)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_rx(bus_rx),
        .frame_go(frame_go), .frame_dir_tx(frame_dir_tx), .frame_id(frame_id),
        .frame_len(frame_len), .resp_byte(resp_byte), .resp_idx(resp_idx),
        .tmo_limit(tmo_limit), .wake_go(wake_go), .wake_delay(wake_delay),
        .flag_clr(flag_clr), .byte_tx_req(byte_tx_req), .byte_tx_data(byte_tx_data),
        .byte_rx_valid(byte_rx_valid), .byte_rx_data(byte_rx_data),
        .brk_drive(brk_drive), .tx_ready(tx_ready), .frame_done(frame_done),
        .rx_dat_valid(rx_dat_valid), .rx_dat(rx_dat), .err_bit(err_bit),
        .err_timeout(err_timeout), .err_csum(err_csum), .wake_flag(wake_flag),
        .sleep_flag(sleep_flag)
    );

    always @(posedge clk) begin
        byte_rx_valid <= 1'b0;
        if (echo_cnt != 0) begin
            echo_cnt <= echo_cnt - 1;
            if (echo_cnt == 1) begin
                byte_rx_valid <= 1'b1;
                byte_rx_data  <= echo_dat;
            end
        end
        if (sl_act) begin
            if (sl_wait == 0) begin
                byte_rx_valid <= 1'b1;
                byte_rx_data  <= sl_bytes[sl_ptr];
                sl_ptr  <= sl_ptr + 1;
                sl_wait <= 11;
                if (sl_ptr == sl_n - 1) sl_act <= 1'b0;
            end else begin
                sl_wait <= sl_wait - 1;
            end
        end
        if (byte_tx_req) begin
            tx_log[log_n] <= byte_tx_data;
            log_n    <= log_n + 1;
            echo_cnt <= 6;
            echo_dat <= byte_tx_data ^ ((log_n == corrupt_at) ? 8'h04 : 8'h00);
            if (slave_en && log_n == 1) begin
                sl_act  <= 1'b1;
                sl_ptr  <= 0;
                sl_wait <= 20;
            end
        end
        if (rx_dat_valid) begin
            rx_log[rx_n] <= rx_dat;
            rx_n <= rx_n + 1;
        end
        if (frame_done) done_n <= done_n + 1;
        if (brk_drive && bit_tick) brk_ticks <= brk_ticks + 1;
        if (clr_log) begin
            log_n = 0; rx_n = 0; done_n = 0; brk_ticks = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] csum_ref(input logic [63:0] dat, input int len);
        logic [7:0] s = 8'h00;
        logic [8:0] t;
        for (int k = 0; k < len; k++) begin
            t = {1'b0, s} + {1'b0, dat[8*k +: 8]};
            s = t[7:0] + {7'd0, t[8]};
        end
        return ~s;
    endfunction

    task automatic start_frame(input logic dir, input logic [7:0] id, input logic [3:0] len);
        @(negedge clk);
        clr_log = 1'b1; frame_dir_tx = dir; frame_id = id; frame_len = len; frame_go = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; frame_go = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (!tx_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            while (!bit_tick) @(negedge clk);
            @(posedge clk);
        end
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = '0;
    endtask

    // id, length, data (byte 0 in the low bits)
    localparam logic [75:0] VEC [4] = '{
        {8'h3C, 4'd1, 64'h0000_0000_0000_0001},
        {8'h97, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF},
        {8'hC1, 4'd2, 64'h0000_0000_0000_8080},
        {8'h20, 4'd4, 64'h0000_0000_4433_2211}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", tx_ready, 1);
        chk("R1 outputs", {brk_drive, byte_tx_req, err_bit, err_timeout, err_csum, wake_flag}, 0);

        // table of transmit frames
        for (int i = 0; i < 4; i++) begin
            logic [7:0] id;
            logic [3:0] len;
            id = VEC[i][75:68]; len = VEC[i][67:64]; cur_data = VEC[i][63:0];
            start_frame(1'b1, id, len);
            wait_ready();
            @(negedge clk);
            chk("R2 break strobes", brk_ticks, 13);
            chk("R3 byte count", log_n, len + 3);
            chk("R3 sync", tx_log[0], 8'h55);
            chk("R3 id", tx_log[1], id);
            for (int k = 0; k < len; k++) chk("R3 data", tx_log[2 + k], cur_data[8*k +: 8]);
            chk("R4 checksum", tx_log[len + 2], csum_ref(cur_data, len));
            chk("R3 done pulses", done_n, 1);
            chk("R5 no false bit error", err_bit, 0);
        end

        // R8: second start during a frame is ignored
        cur_data = VEC[3][63:0];
        start_frame(1'b1, 8'h20, 4'd4);
        repeat (30) @(negedge clk);
        frame_id = 8'h7E; frame_go = 1'b1;
        @(negedge clk); frame_go = 1'b0;
        wait_ready();
        @(negedge clk);
        chk("R8 count unchanged", log_n, 7);
        chk("R8 id unchanged", tx_log[1], 8'h20);

        // R5: corrupt readback of first data byte
        corrupt_at = 2;
        start_frame(1'b1, 8'h20, 4'd4);
        while (!(byte_rx_valid && log_n == 3)) @(negedge clk);
        @(negedge clk);
        chk("R5 ready after mismatch", tx_ready, 1);
        chk("R5 bit error", err_bit, 1);
        repeat (40) @(negedge clk);
        chk("R5 no more requests", log_n, 3);
        corrupt_at = 99;

        // R6: receive frame with good checksum
        sl_bytes[0] = 8'h10; sl_bytes[1] = 8'h20; sl_bytes[2] = 8'h30; sl_bytes[3] = 8'h9F;
        sl_n = 4; slave_en = 1'b1; tmo_limit = 16'd2000;
        start_frame(1'b0, 8'h42, 4'd3);
        wait_ready();
        @(negedge clk);
        chk("R6 header only", log_n, 2);
        chk("R6 rx count", rx_n, 3);
        chk("R6 rx byte0", rx_log[0], 8'h10);
        chk("R6 rx byte2", rx_log[2], 8'h30);
        chk("R6 done", done_n, 1);
        chk("R7 no early timeout", {err_timeout, err_csum}, 0);

        // R6: bad checksum
        sl_bytes[3] = 8'h9E;
        start_frame(1'b0, 8'h42, 4'd3);
        wait_ready();
        @(negedge clk);
        chk("R6 csum error", err_csum, 1);
        chk("R6 no done on bad csum", done_n, 0);

        // R7: silent slave, exact budget
        slave_en = 1'b0; tmo_limit = 16'd150;
        begin
            int n = 0;
            @(negedge clk);
            frame_dir_tx = 1'b0; frame_go = 1'b1;
            @(negedge clk); frame_go = 1'b0;
            while (!tx_ready && n < 3000) begin n++; @(negedge clk); end
            chk("R7 busy cycles", n, 150);
            chk("R7 timeout flag", err_timeout, 1);
        end

        // R9: wake break and hold-off, with an ignored start
        pulse_clr(4'hF);
        @(negedge clk);
        clr_log = 1'b1; wake_go = 1'b1;
        @(negedge clk); clr_log = 1'b0; wake_go = 1'b0;
        while (brk_drive) @(negedge clk);
        begin
            int n = 0;
            while (!tx_ready && n < 3000) begin
                n++;
                frame_go = (n == 10);
                @(negedge clk);
            end
            frame_go = 1'b0;
            chk("R9 hold-off cycles", n, 44);
        end
        chk("R2 wake break strobes", brk_ticks, 13);
        repeat (100) @(negedge clk);
        chk("R8 start ignored in hold-off", log_n, 0);
        chk("R10 own break not flagged", wake_flag, 0);

        // R10: external low periods
        ext_low = 1'b1; repeat (32) @(negedge clk); ext_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 short low ignored", wake_flag, 0);
        ext_low = 1'b1; repeat (50) @(negedge clk); ext_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 long low flagged", wake_flag, 1);

        // R11: selective clear
        corrupt_at = 2;
        cur_data = VEC[0][63:0];
        start_frame(1'b1, 8'h3C, 4'd1);
        wait_ready();
        corrupt_at = 99;
        slave_en = 1'b0; tmo_limit = 16'd150;
        start_frame(1'b0, 8'h11, 4'd1);
        wait_ready();
        sl_bytes[0] = 8'h01; sl_bytes[1] = 8'h00; sl_n = 2; slave_en = 1'b1;
        tmo_limit = 16'd2000;
        start_frame(1'b0, 8'h11, 4'd1);
        wait_ready();
        slave_en = 1'b0;
        @(negedge clk);
        chk("R11 all set", {err_bit, err_timeout, err_csum, wake_flag}, 4'hF);
        pulse_clr(4'b0010);
        chk("R11 timeout cleared only", {err_bit, err_timeout, err_csum, wake_flag}, 4'b1011);
        pulse_clr(4'b1101);
        chk("R11 all cleared", {err_bit, err_timeout, err_csum, wake_flag}, 4'h0);

        // R12: sleep indication
        @(negedge clk); ext_low = 1'b1;
        @(negedge clk); @(negedge clk); ext_low = 1'b0;
        @(posedge clk);
        wait_ticks(SLP - 1);
        @(negedge clk);
        chk("R12 not yet asleep", sleep_flag, 0);
        wait_ticks(1);
        @(negedge clk);
        chk("R12 asleep", sleep_flag, 1);
        ext_low = 1'b1;
        @(negedge clk);
        chk("R12 edge wakes", sleep_flag, 0);
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
        pulse_clr(4'hF);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule